// File: doc/BRIEF.md
# Twelve-Bit Instruction Execute Stage

This block is the decode and execute stage of a small accumulator processor that uses 12-bit instruction words and 8-bit data. Each cycle it takes an instruction word, the working register W, the operand byte already read from a 32-entry register file (addressed by the low five instruction bits), and the current carry flag. It decides which operation the word encodes, performs it, and reports where the result goes, which of the carry, digit-carry and zero flags change and to what, and whether the next instruction should be skipped.

The surrounding pipeline owns the program counter, the call stack, jump targets, the register file and the flag register. It uses `w_we` and `file_we` to commit `result`, each `*_upd` strobe to commit the matching flag value, and `skip_req` to squash the next fetched word. All outputs are registered and reflect the inputs sampled at the previous rising clock edge.

Top module: `exu12_core`

## Requirements
- R1: For byte-oriented forms (top two bits 00), instruction bit 5 selects the destination. 0 raises `w_we` and 1 raises `file_we`. The two enables are never high together. Every output appears one clock after its inputs are sampled.
- R2: Add (0001 11df ffff) yields file+W modulo 256. C is the carry out of bit 7, DC is the carry out of bit 3, and Z marks a zero result. All three update strobes are raised.
- R3: Subtract (0000 10df ffff) yields file−W modulo 256. C is 1 exactly when file ≥ W, DC is 1 exactly when file[3:0] ≥ W[3:0], and Z marks zero. All three strobes are raised.
- R4: Move-to-self (0010 00), complement (0010 01), increment (0010 10), decrement (0000 11), OR (0001 00), AND (0001 01) and XOR (0001 10) raise only the Z strobe.
- R5: Rotate right (0011 00) yields {C, f[7:1]} with new C = f[0]. Rotate left (0011 01) yields {f[6:0], C} with new C = f[7]. Only the C strobe is raised.
- R6: The W-to-file move (0000 001f ffff) writes W to the file and swap (0011 10df ffff) yields {f[3:0], f[7:4]}. Neither raises any flag strobe.
- R7: Bit clear (0100 bbbf ffff) and bit set (0101 bbbf ffff) write the file byte with bit b (instruction bits 7..5) forced to 0 or 1. Neither writes W nor raises any flag strobe.
- R8: Bit test (0110 skips when bit b is 0, 0111 skips when it is 1) raises `skip_req` on that condition. It writes nothing and raises no strobe.
- R9: Increment-and-skip (0011 11df ffff) and decrement-and-skip (0010 11df ffff) write per bit 5 and raise `skip_req` when the result is zero. They raise no flag strobe.
- R10: Literal forms load W (1100 kkkk kkkk) or combine k into W by OR (1101), AND (1110) or XOR (1111). They write only W. The three combining forms raise only the Z strobe and the load raises none.
- R11: Clear-W (exactly 0000 0100 0000) and clear-file (0000 011f ffff) give result 0 with Z = 1 and the Z strobe raised.
- R12: Words in 0000 000x xxxx, 0000 010x xxxx other than clear-W, and 10xx xxxx xxxx produce no write, no flag strobe and no skip.
- R13: While `rst_n` is low at a rising edge, every output is cleared to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 12 | Instruction word |
| w_in | input | 8 | Working register value |
| f_in | input | 8 | Operand byte read from the register file |
| c_in | input | 1 | Current carry flag |
| result | output | 8 | Value to write to the selected destination |
| w_we | output | 1 | Write result to W |
| file_we | output | 1 | Write result back to the addressed file byte |
| c_out | output | 1 | New carry value |
| dc_out | output | 1 | New digit-carry value |
| z_out | output | 1 | New zero value |
| c_upd | output | 1 | Commit `c_out` |
| dc_upd | output | 1 | Commit `dc_out` |
| z_upd | output | 1 | Commit `z_out` |
| skip_req | output | 1 | Skip the next instruction |

## Verification
Uniformly random 12-bit words with random W, file and carry values cover every opcode region, including the unrecognised ones. These words separate the destination bit from the opcode and expose any flag strobe raised by the wrong family. Directed cases then target the arithmetic edges: a sum that wraps to zero, subtraction with equal operands and with a borrow only in the low nibble, a rotate that moves a carry in and out, increment from 0xFF and decrement from 0x01 for the skip, and bit tests on bit 7. These edges tell apart off-by-one carry and digit-carry rules, inverted borrow polarity and wrong bit indexing. Reset is checked both with and without an instruction presented.

// File: rtl/exu12_pkg.sv
// Package exu12_pkg
// Shared widths, operation codes and the decoded control bundle for the
// twelve-bit execute stage. Assumes an 8-bit datapath split into nibbles.
package exu12_pkg;

    localparam int DATA_W = 8;
    localparam int INSN_W = 12;
    localparam int NIB_W  = DATA_W / 2;
    localparam int BIDX_W = $clog2(DATA_W);
    localparam int FADR_W = 5;

    typedef enum logic [4:0] {
        OP_NONE,
        OP_PASS_A,
        OP_PASS_B,
        OP_ZERO,
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_IOR,
        OP_XOR,
        OP_COM,
        OP_INC,
        OP_DEC,
        OP_RLC,
        OP_RRC,
        OP_SWAP,
        OP_BCLR,
        OP_BSET
    } alu_op_e;

    typedef enum logic [1:0] {
        SK_NONE,
        SK_ZERO,
        SK_BIT_LO,
        SK_BIT_HI
    } skip_e;

    typedef struct packed {
        alu_op_e op;
        logic    use_lit;
        logic    w_we;
        logic    f_we;
        logic    c_en;
        logic    dc_en;
        logic    z_en;
        skip_e   skip;
    } ctl_t;

endpackage

// File: rtl/exu12_decode.sv
// Module exu12_decode
// Pure combinational decoder: maps a 12-bit instruction word to the ALU
// operation, operand source, write enables, flag update strobes and skip
// rule. Assumes any encoding not listed below is a no-op (all zero).
module exu12_decode
    import exu12_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    output ctl_t              ctl
);

    localparam int DBIT = FADR_W;

    // Destination pair {file, W} taken from the d bit.
    logic [1:0] dsel;
    assign dsel = {instr[DBIT], ~instr[DBIT]};

    // Decode the instruction word into the control bundle.
    always_comb begin
        ctl      = '0;
        ctl.op   = OP_NONE;
        ctl.skip = SK_NONE;
        casez (instr)
            12'b0000_001?_????: begin
                ctl.op   = OP_PASS_A;
                ctl.f_we = 1'b1;
            end
            12'b0000_0100_0000: begin
                ctl.op   = OP_ZERO;
                ctl.w_we = 1'b1;
                ctl.z_en = 1'b1;
            end
            12'b0000_011?_????: begin
                ctl.op   = OP_ZERO;
                ctl.f_we = 1'b1;
                ctl.z_en = 1'b1;
            end
            12'b0000_10??_????: begin
                ctl.op               = OP_SUB;
                {ctl.f_we, ctl.w_we} = dsel;
                ctl.c_en             = 1'b1;
                ctl.dc_en            = 1'b1;
                ctl.z_en             = 1'b1;
            end
            12'b0000_11??_????: begin
                ctl.op               = OP_DEC;
                {ctl.f_we, ctl.w_we} = dsel;
                ctl.z_en             = 1'b1;
            end
            12'b0001_00??_????: begin
                ctl.op               = OP_IOR;
                {ctl.f_we, ctl.w_we} = dsel;
                ctl.z_en             = 1'b1;
            end
            12'b0001_01??_????: begin
                ctl.op               = OP_AND;
                {ctl.f_we, ctl.w_we} = dsel;
                ctl.z_en             = 1'b1;
            end
            12'b0001_10??_????: begin
                ctl.op               = OP_XOR;
                {ctl.f_we, ctl.w_we} = dsel;
                ctl.z_en             = 1'b1;
            end
            12'b0001_11??_????: begin
                ctl.op               = OP_ADD;
                {ctl.f_we, ctl.w_we} = dsel;
                ctl.c_en             = 1'b1;
                ctl.dc_en            = 1'b1;
                ctl.z_en             = 1'b1;
            end
            12'b0010_00??_????: begin
                ctl.op               = OP_PASS_B;
                {ctl.f_we, ctl.w_we} = dsel;
                ctl.z_en             = 1'b1;
            end
            12'b0010_01??_????: begin
                ctl.op               = OP_COM;
                {ctl.f_we, ctl.w_we} = dsel;
                ctl.z_en             = 1'b1;
            end
            12'b0010_10??_????: begin
                ctl.op               = OP_INC;
                {ctl.f_we, ctl.w_we} = dsel;
                ctl.z_en             = 1'b1;
            end
            12'b0010_11??_????: begin
                ctl.op               = OP_DEC;
                {ctl.f_we, ctl.w_we} = dsel;
                ctl.skip             = SK_ZERO;
            end
            12'b0011_00??_????: begin
                ctl.op               = OP_RRC;
                {ctl.f_we, ctl.w_we} = dsel;
                ctl.c_en             = 1'b1;
            end
            12'b0011_01??_????: begin
                ctl.op               = OP_RLC;
                {ctl.f_we, ctl.w_we} = dsel;
                ctl.c_en             = 1'b1;
            end
            12'b0011_10??_????: begin
                ctl.op               = OP_SWAP;
                {ctl.f_we, ctl.w_we} = dsel;
            end
            12'b0011_11??_????: begin
                ctl.op               = OP_INC;
                {ctl.f_we, ctl.w_we} = dsel;
                ctl.skip             = SK_ZERO;
            end
            12'b0100_????_????: begin
                ctl.op   = OP_BCLR;
                ctl.f_we = 1'b1;
            end
            12'b0101_????_????: begin
                ctl.op   = OP_BSET;
                ctl.f_we = 1'b1;
            end
            12'b0110_????_????: ctl.skip = SK_BIT_LO;
            12'b0111_????_????: ctl.skip = SK_BIT_HI;
            12'b1100_????_????: begin
                ctl.op      = OP_PASS_B;
                ctl.use_lit = 1'b1;
                ctl.w_we    = 1'b1;
            end
            12'b1101_????_????: begin
                ctl.op      = OP_IOR;
                ctl.use_lit = 1'b1;
                ctl.w_we    = 1'b1;
                ctl.z_en    = 1'b1;
            end
            12'b1110_????_????: begin
                ctl.op      = OP_AND;
                ctl.use_lit = 1'b1;
                ctl.w_we    = 1'b1;
                ctl.z_en    = 1'b1;
            end
            12'b1111_????_????: begin
                ctl.op      = OP_XOR;
                ctl.use_lit = 1'b1;
                ctl.w_we    = 1'b1;
                ctl.z_en    = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/exu12_alu.sv
// Module exu12_alu
// Combinational 8-bit ALU. Operand a is always W; operand b is the file
// byte or the literal. Add and subtract share one adder (subtract is b
// plus the complement of a plus one, so its carry is an inverted borrow).
// Assumes the caller only commits flags whose strobe the decoder raised.
module exu12_alu
    import exu12_pkg::*;
(
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              c_in,
    input  logic [BIDX_W-1:0] bit_idx,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              dc_out,
    output logic              bit_val
);

    logic [DATA_W-1:0] bit_sel;

    // One-hot mask of the addressed bit.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign bit_sel[g] = (bit_idx == BIDX_W'(g));
    end

    assign bit_val = |(b & bit_sel);

    logic              is_sub;
    logic [DATA_W-1:0] addend;
    logic [DATA_W:0]   sum;
    logic [NIB_W:0]    nib_sum;

    // Shared adder for add and subtract.
    always_comb begin
        is_sub  = (op == OP_SUB);
        addend  = is_sub ? ~a : a;
        sum     = {1'b0, b} + {1'b0, addend} + {{DATA_W{1'b0}}, is_sub};
        nib_sum = {1'b0, b[NIB_W-1:0]} + {1'b0, addend[NIB_W-1:0]}
                + {{NIB_W{1'b0}}, is_sub};
    end

    // Result and carry selection per operation.
    always_comb begin
        res    = '0;
        c_out  = c_in;
        dc_out = nib_sum[NIB_W];
        unique case (op)
            OP_NONE:   res = '0;
            OP_PASS_A: res = a;
            OP_PASS_B: res = b;
            OP_ZERO:   res = '0;
            OP_ADD,
            OP_SUB: begin
                res   = sum[DATA_W-1:0];
                c_out = sum[DATA_W];
            end
            OP_AND:    res = a & b;
            OP_IOR:    res = a | b;
            OP_XOR:    res = a ^ b;
            OP_COM:    res = ~b;
            OP_INC:    res = b + 1'b1;
            OP_DEC:    res = b - 1'b1;
            OP_RLC: begin
                res   = {b[DATA_W-2:0], c_in};
                c_out = b[DATA_W-1];
            end
            OP_RRC: begin
                res   = {c_in, b[DATA_W-1:1]};
                c_out = b[0];
            end
            OP_SWAP:   res = {b[NIB_W-1:0], b[DATA_W-1:NIB_W]};
            OP_BCLR:   res = b & ~bit_sel;
            OP_BSET:   res = b | bit_sel;
            default:   res = '0;
        endcase
    end

endmodule

// File: rtl/exu12_core.sv
// Module exu12_core
// Top of the execute stage: decodes the instruction, runs the ALU, forms
// the skip request and registers every output for one cycle. Assumes the
// register file read for f_in is already complete when instr is presented.
module exu12_core
    import exu12_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] instr,
    input  logic [DATA_W-1:0] w_in,
    input  logic [DATA_W-1:0] f_in,
    input  logic              c_in,
    output logic [DATA_W-1:0] result,
    output logic              w_we,
    output logic              file_we,
    output logic              c_out,
    output logic              dc_out,
    output logic              z_out,
    output logic              c_upd,
    output logic              dc_upd,
    output logic              z_upd,
    output logic              skip_req
);

    localparam int BIT_LSB = FADR_W;

    ctl_t              ctl;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] alu_res;
    logic              alu_c;
    logic              alu_dc;
    logic              alu_bit;
    logic              skip_d;

    exu12_decode u_dec (
        .instr (instr),
        .ctl   (ctl)
    );

    // Second operand: literal for immediate forms, else the file byte.
    assign opnd_b = ctl.use_lit ? instr[DATA_W-1:0] : f_in;

    exu12_alu u_alu (
        .op      (ctl.op),
        .a       (w_in),
        .b       (opnd_b),
        .c_in    (c_in),
        .bit_idx (instr[BIT_LSB +: BIDX_W]),
        .res     (alu_res),
        .c_out   (alu_c),
        .dc_out  (alu_dc),
        .bit_val (alu_bit)
    );

    // Skip request from the decoded rule.
    always_comb begin
        unique case (ctl.skip)
            SK_ZERO:   skip_d = (alu_res == '0);
            SK_BIT_LO: skip_d = ~alu_bit;
            SK_BIT_HI: skip_d = alu_bit;
            default:   skip_d = 1'b0;
        endcase
    end

    // Output register stage with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            w_we     <= 1'b0;
            file_we  <= 1'b0;
            c_out    <= 1'b0;
            dc_out   <= 1'b0;
            z_out    <= 1'b0;
            c_upd    <= 1'b0;
            dc_upd   <= 1'b0;
            z_upd    <= 1'b0;
            skip_req <= 1'b0;
        end else begin
            result   <= alu_res;
            w_we     <= ctl.w_we;
            file_we  <= ctl.f_we;
            c_out    <= alu_c;
            dc_out   <= alu_dc;
            z_out    <= (alu_res == '0);
            c_upd    <= ctl.c_en;
            dc_upd   <= ctl.dc_en;
            z_upd    <= ctl.z_en;
            skip_req <= skip_d;
        end
    end

    AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        !(w_we && file_we)); // R1

    AST_ADD_ALL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr[11:6]) == 6'b000111)
        |-> (c_upd && dc_upd && z_upd)); // R2

    AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr[11:6]) == 6'b000010)
        |-> (c_out == ($past(f_in) >= $past(w_in)))); // R3

    AST_ROT_C_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr[11:7]) == 5'b00110)
        |-> (c_upd && !dc_upd && !z_upd)); // R5

    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> !(c_upd || dc_upd || z_upd)); // R8

    AST_LIT_NO_FILE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr[11:10]) == 2'b11)
        |-> (!file_we && w_we)); // R10

    AST_CLEAR_Z: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr) == 12'h040)
        |-> (z_upd && z_out && result == '0)); // R11

    AST_UNREC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr[11:10]) == 2'b10)
        |-> !(w_we || file_we || skip_req || c_upd || dc_upd || z_upd)); // R12

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !(w_we || file_we || skip_req || c_upd || z_upd)
                          && result == '0); // R13

endmodule

// File: tb/sim_exu12_core.sv
// Bench for exu12_core: fixed-seed random words plus directed corners,
// checked against a model written from the requirements.
module sim_exu12_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] instr = '0;
    logic [7:0]  w_in = '0;
    logic [7:0]  f_in = '0;
    logic        c_in = 1'b0;
    logic [7:0]  result;
    logic        w_we, file_we, c_out, dc_out, z_out;
    logic        c_upd, dc_upd, z_upd, skip_req;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    exu12_core u0 (
        .clk(clk), .rst_n(rst_n), .instr(instr), .w_in(w_in), .f_in(f_in),
        .c_in(c_in), .result(result), .w_we(w_we), .file_we(file_we),
        .c_out(c_out), .dc_out(dc_out), .z_out(z_out), .c_upd(c_upd),
        .dc_upd(dc_upd), .z_upd(z_upd), .skip_req(skip_req)
    );

    typedef struct packed {
        logic [7:0] res;
        logic wwe, fwe, c, dc, z, cen, dcen, zen, skip;
    } exp_t;

    function automatic string tag_of(input logic [11:0] i);
        if (i[11:10] == 2'b10) return "R12";
        if (i[11:10] == 2'b11) return "R10";
        if (i[11:10] == 2'b01) return i[9] ? "R8" : "R7";
        if (i[11:6] == 6'b0) return i[5] ? "R6" : "R12";
        if (i == 12'h040 || i[11:5] == 7'b0000011) return "R11";
        case (i[9:6])
            4'b0111: return "R2";
            4'b0010: return "R3";
            4'b1100, 4'b1101: return "R5";
            4'b1110: return "R6";
            4'b1011, 4'b1111: return "R9";
            4'b0001: return "R12";
            default: return "R4";
        endcase
    endfunction

    function automatic exp_t model(input logic [11:0] i, input logic [7:0] w,
                                   input logic [7:0] f, input logic c);
        exp_t e = '0;
        logic [7:0] k = i[7:0];
        logic [2:0] b = i[7:5];
        bit valid = 1'b1;
        if (i[11:6] == 6'b0) begin
            if (i[5]) begin e.res = w; e.fwe = 1; end
        end else if (i == 12'h040) begin
            e.wwe = 1; e.z = 1; e.zen = 1;
        end else if (i[11:5] == 7'b0000011) begin
            e.fwe = 1; e.z = 1; e.zen = 1;
        end else if (i[11:10] == 2'b00) begin
            case (i[9:6])
                4'b0010: begin e.res = f - w; e.c = (f >= w);
                    e.dc = (f[3:0] >= w[3:0]); e.cen = 1; e.dcen = 1; e.zen = 1; end
                4'b0011: begin e.res = f - 8'd1; e.zen = 1; end
                4'b0100: begin e.res = f | w; e.zen = 1; end
                4'b0101: begin e.res = f & w; e.zen = 1; end
                4'b0110: begin e.res = f ^ w; e.zen = 1; end
                4'b0111: begin e.res = f + w; e.c = (9'(f) + 9'(w)) > 9'd255;
                    e.dc = (5'(f[3:0]) + 5'(w[3:0])) > 5'd15;
                    e.cen = 1; e.dcen = 1; e.zen = 1; end
                4'b1000: begin e.res = f; e.zen = 1; end
                4'b1001: begin e.res = ~f; e.zen = 1; end
                4'b1010: begin e.res = f + 8'd1; e.zen = 1; end
                4'b1011: begin e.res = f - 8'd1; e.skip = (f == 8'd1); end
                4'b1100: begin e.res = {c, f[7:1]}; e.c = f[0]; e.cen = 1; end
                4'b1101: begin e.res = {f[6:0], c}; e.c = f[7]; e.cen = 1; end
                4'b1110: e.res = {f[3:0], f[7:4]};
                4'b1111: begin e.res = f + 8'd1; e.skip = (f == 8'hFF); end
                default: valid = 1'b0;
            endcase
            if (valid) begin e.fwe = i[5]; e.wwe = !i[5]; e.z = (e.res == 0); end
        end else if (i[11:10] == 2'b01) begin
            case (i[9:8])
                2'b00: begin e.res = f & ~(8'd1 << b); e.fwe = 1; end
                2'b01: begin e.res = f | (8'd1 << b); e.fwe = 1; end
                2'b10: e.skip = !f[b];
                default: e.skip = f[b];
            endcase
        end else if (i[11:10] == 2'b11) begin
            e.wwe = 1;
            case (i[9:8])
                2'b00: e.res = k;
                2'b01: begin e.res = w | k; e.zen = 1; end
                2'b10: begin e.res = w & k; e.zen = 1; end
                default: begin e.res = w ^ k; e.zen = 1; end
            endcase
            e.z = (e.res == 0);
        end
        return e;
    endfunction

    task automatic check_zero(input string why);
        n_run++;
        if (result != 0 || w_we || file_we || c_upd || dc_upd || z_upd || skip_req
            || c_out || dc_out || z_out) begin
            n_fail++;
            $display("FAIL R13 %s: outputs res=%h we=%b%b upd=%b%b%b skip=%b, expected all 0",
                     why, result, w_we, file_we, c_upd, dc_upd, z_upd, skip_req);
        end
    endtask

    task automatic run(input logic [11:0] i, input logic [7:0] w,
                       input logic [7:0] f, input logic c);
        exp_t e;
        bit bad;
        @(negedge clk);
        instr = i; w_in = w; f_in = f; c_in = c;
        e = model(i, w, f, c);
        @(negedge clk);
        n_run++;
        // Byte-form destinations are judged by R1 in the same comparison.
        bad = (w_we !== e.wwe) || (file_we !== e.fwe) || (c_upd !== e.cen)
           || (dc_upd !== e.dcen) || (z_upd !== e.zen) || (skip_req !== e.skip)
           || ((e.wwe || e.fwe) && result !== e.res)
           || (e.cen && c_out !== e.c) || (e.dcen && dc_out !== e.dc)
           || (e.zen && z_out !== e.z);
        if (bad) begin
            n_fail++;
            $display("FAIL %s (dest per R1) instr=%h w=%h f=%h c=%b: got res=%h w/f=%b%b cdz=%b%b%b upd=%b%b%b skip=%b, expected res=%h w/f=%b%b cdz=%b%b%b upd=%b%b%b skip=%b",
                     tag_of(i), i, w, f, c, result, w_we, file_we, c_out, dc_out, z_out,
                     c_upd, dc_upd, z_upd, skip_req, e.res, e.wwe, e.fwe, e.c, e.dc, e.z,
                     e.cen, e.dcen, e.zen, e.skip);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_zero("idle reset");                   // R13
        instr = 12'h1C0; w_in = 8'h33; f_in = 8'h44;
        @(negedge clk);
        check_zero("word presented in reset");      // R13
        rst_n = 1'b1;

        run(12'h1E3, 8'h01, 8'hFF, 1'b0);           // R2 wrap to zero, C and DC set
        run(12'h1C3, 8'h08, 8'h08, 1'b0);           // R2 DC only
        run(12'h0A3, 8'h05, 8'h05, 1'b0);           // R3 equal operands
        run(12'h083, 8'h01, 8'h10, 1'b1);           // R3 low-nibble borrow
        run(12'h0A3, 8'h80, 8'h7F, 1'b1);           // R3 full borrow
        run(12'h363, 8'h00, 8'h80, 1'b1);           // R5 left through carry
        run(12'h303, 8'h00, 8'h01, 1'b0);           // R5 right through carry
        run(12'h2C3, 8'h00, 8'h01, 1'b0);           // R9 decrement to zero
        run(12'h3E3, 8'h00, 8'hFF, 1'b0);           // R9 increment wraps
        run(12'h7E3, 8'h00, 8'h80, 1'b0);           // R8 bit 7 set skip
        run(12'h6E3, 8'h00, 8'h80, 1'b0);           // R8 bit 7 set no skip
        run(12'h4E3, 8'h00, 8'hFF, 1'b0);           // R7 clear bit 7
        run(12'h503, 8'h00, 8'h00, 1'b0);           // R7 set bit 0
        run(12'h040, 8'h5A, 8'h5A, 1'b1);           // R11 clear W
        run(12'h041, 8'h5A, 8'h5A, 1'b1);           // R12 near clear W
        run(12'h068, 8'h5A, 8'h5A, 1'b1);           // R11 clear file
        run(12'h800, 8'h5A, 8'h5A, 1'b1);           // R12
        run(12'hA55, 8'h5A, 8'h00, 1'b1);           // R12
        run(12'h003, 8'h5A, 8'h00, 1'b1);           // R12
        run(12'h02F, 8'h5A, 8'h00, 1'b1);           // R6 W to file
        run(12'h3A3, 8'h00, 8'h3C, 1'b1);           // R6 swap
        run(12'hE00, 8'hFF, 8'h00, 1'b0);           // R10 AND to zero
        run(12'hC00, 8'hFF, 8'h00, 1'b0);           // R10 load no flags
        run(12'h220, 8'h00, 8'h00, 1'b0);           // R4 move-to-self zero
        run(12'h1A0, 8'hAA, 8'hAA, 1'b0);           // R4 XOR to zero

        for (int n = 0; n < 4000; n++)
            run(12'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));

        @(negedge clk);
        rst_n = 1'b0;
        instr = 12'h1E3;
        @(negedge clk);
        check_zero("reset after traffic");          // R13

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule